// File: doc/BRIEF.md
# Bypass-Aware Operand Read Gate

This block sits in a pipeline stage of its own, directly ahead of register fetch. For each of the two source operands of the instruction offered for issue, it decides where the value comes from. A source can be taken from a forwarding path, read from the register file, or not be ready yet. A register file read port is enabled only when no forwarding path will deliver the operand. This replaces the usual scheme of reading every port and every bypass speculatively and picking one afterwards, so reads that would be thrown away are never made.

The block keeps a small table of instructions already in flight. Each entry records the destination register, the number of cycles since that instruction issued (its age), and two latencies taken from its operation class. The first latency is the age at which the result exists. The second is the age at which the result has been written to the register file. Some classes lack a forwarding path at certain ages. A source whose producer is too young, or sits at an age with no path, raises a stall, and the instruction is held. Two saturating counters report how many register file reads were made and how many operands were forwarded.

Each table entry is a small state machine with three states. FREE holds nothing. BUSY holds a producer whose result does not exist yet. READY holds a producer whose result can be forwarded. The transitions are:
- alloc: FREE→BUSY or FREE→READY, depending on the first latency. A READY entry that retires in the same cycle can also take the new instruction.
- compute: BUSY→READY, when the age reaches the first latency.
- retire: READY→FREE, at the second latency.

Top module: `bypass_read_gate`

## Requirements
- R1: After reset the table is empty, both counters read 0 and stall is low. An instruction whose sources are nonzero then reads both from the register file.
- R2: Operation classes and their latencies (first/second) are: code 0 is 1/2, code 1 is 1/3, code 2 is 2/4 and code 3 is 3/4. Only code 3 lacks a forwarding path, and only at age 4.
- R3: A source whose youngest matching producer has an age from the first to the second latency, with a path present, is forwarded. Its read enable is low and its select equals that age (1..4). A select of 0 means no forwarding.
- R4: A source whose youngest matching producer is younger than the first latency raises stall. While stall is high both read enables and both selects are 0, nothing is counted, and the instruction does not enter the table.
- R5: A producer leaves the table after its second latency. A later source naming its register reads the register file.
- R6: A code-3 producer seen at age 4 (missing path) causes a stall, not a forward or a read.
- R7: When several in-flight producers write the same register, only the youngest one decides the source's outcome.
- R8: Register 0 as a source never reads, never forwards and never stalls. Register 0 as a destination is not tracked.
- R9: The two sources are resolved independently. Stall is raised when either one is not ready.
- R10: On each issued instruction (valid and not stalled), the read counter adds the number of read enables and the forward counter adds the number of forwarded sources. Both counters saturate at all ones.
- R11: An instruction may issue every cycle, and there is always a free or retiring entry for its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is offered for issue |
| instr_dst | input | REG_W | Destination register (0 = none) |
| instr_cls | input | 2 | Operation class code |
| src_a | input | REG_W | First source register |
| src_b | input | REG_W | Second source register |
| rd_en_a | output | 1 | Register file read enable, first source |
| rd_en_b | output | 1 | Register file read enable, second source |
| sel_a | output | AGE_W | Forwarding select (producer age), first source |
| sel_b | output | AGE_W | Forwarding select (producer age), second source |
| stall | output | 1 | Hold the offered instruction |
| rf_reads | output | CNT_W | Saturating count of register file reads |
| byp_hits | output | CNT_W | Saturating count of forwarded sources |

## Verification
The assertions check on every cycle the properties that hold one step at a time. Each entry's age stays inside its window, and a BUSY entry is always younger than its first latency. A stall never coexists with a read, and source register 0 never reads. Allocation always finds a slot, and the counters never decrease. Whether the right producer was chosen, the select value, and the exact age at which a stall turns into a forward or a read can only be shown by the bench's scenarios. These include back-to-back writes to one register, the code-3 missing path, and the counters reaching saturation, all compared with a reference table kept in the bench.

// File: rtl/bypass_gate_pkg.sv
package bypass_gate_pkg;

    localparam int AGE_W  = 3;
    localparam int PATH_W = 1 << AGE_W;

    typedef enum logic [1:0] {
        CLS_ALU   = 2'd0,
        CLS_SHIFT = 2'd1,
        CLS_MUL   = 2'd2,
        CLS_LOAD  = 2'd3
    } op_cls_e;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_READY = 2'd2
    } ent_st_e;

    typedef struct packed {
        logic [AGE_W-1:0]  l1;
        logic [AGE_W-1:0]  l2;
        logic [PATH_W-1:0] path;
    } lat_t;

    // Age at which the result exists.
    function automatic logic [AGE_W-1:0] l1_of(op_cls_e c);
        case (c)
            CLS_ALU:   return AGE_W'(1);
            CLS_SHIFT: return AGE_W'(1);
            CLS_MUL:   return AGE_W'(2);
            default:   return AGE_W'(3);
        endcase
    endfunction

    // Full latency record: bit k of path set when a forward exists at age k.
    function automatic lat_t lat_of(op_cls_e c);
        lat_t t;
        t.l1 = l1_of(c);
        case (c)
            CLS_ALU:   begin t.l2 = AGE_W'(2); t.path = PATH_W'(8'b0000_0110); end
            CLS_SHIFT: begin t.l2 = AGE_W'(3); t.path = PATH_W'(8'b0000_1110); end
            CLS_MUL:   begin t.l2 = AGE_W'(4); t.path = PATH_W'(8'b0001_1100); end
            default:   begin t.l2 = AGE_W'(4); t.path = PATH_W'(8'b0000_1000); end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/bgate_entry.sv
module bgate_entry
    import bypass_gate_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc,
    input  logic [REG_W-1:0]     alloc_dst,
    input  logic [1:0]           alloc_cls,
    output logic                 vld,
    output logic                 retire,
    output logic [REG_W-1:0]     dst,
    output logic [AGE_W-1:0]     age,
    output logic [AGE_W-1:0]     l1,
    output logic [PATH_W-1:0]    path
);

    ent_st_e           state_q, state_n;
    logic [AGE_W-1:0]  age_q, age_n, age_inc;
    logic [REG_W-1:0]  dst_q, dst_n;
    op_cls_e           cls_q, cls_n;
    lat_t              lat;

    assign lat     = lat_of(cls_q);
    assign age_inc = age_q + 1'b1;

    always_comb begin
        state_n = state_q;
        age_n   = age_q;
        dst_n   = dst_q;
        cls_n   = cls_q;
        if (alloc) begin
            cls_n   = op_cls_e'(alloc_cls);
            dst_n   = alloc_dst;
            age_n   = AGE_W'(1);
            state_n = (l1_of(op_cls_e'(alloc_cls)) == AGE_W'(1)) ? ST_READY : ST_BUSY;
        end else begin
            unique case (state_q)
                ST_FREE: ;
                ST_BUSY: begin
                    age_n = age_inc;
                    if (age_inc >= lat.l1) state_n = ST_READY;
                end
                ST_READY: begin
                    if (age_q == lat.l2) state_n = ST_FREE;
                    else                 age_n   = age_inc;
                end
                default: state_n = ST_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            age_q   <= '0;
            dst_q   <= '0;
            cls_q   <= CLS_ALU;
        end else begin
            state_q <= state_n;
            age_q   <= age_n;
            dst_q   <= dst_n;
            cls_q   <= cls_n;
        end
    end

    always_comb begin
        vld    = (state_q != ST_FREE);
        retire = (state_q == ST_READY) && (age_q == lat.l2);
        dst    = dst_q;
        age    = age_q;
        l1     = lat.l1;
        path   = lat.path;
    end

    AST_AGE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FREE) |-> (age_q >= AGE_W'(1) && age_q <= lat.l2)); // R5
    AST_BUSY_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> (age_q < lat.l1)); // R4
    AST_READY_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY) |-> (age_q >= lat.l1)); // R3

endmodule

// File: rtl/bgate_resolve.sv
module bgate_resolve
    import bypass_gate_pkg::*;
#(
    parameter int NENT  = 4,
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0]              src,
    input  logic [NENT-1:0]               e_vld,
    input  logic [NENT-1:0][REG_W-1:0]    e_dst,
    input  logic [NENT-1:0][AGE_W-1:0]    e_age,
    input  logic [NENT-1:0][AGE_W-1:0]    e_l1,
    input  logic [NENT-1:0][PATH_W-1:0]   e_path,
    output logic                          need_rf,
    output logic                          use_byp,
    output logic                          hazard,
    output logic [AGE_W-1:0]              sel
);

    logic              hit;
    logic [AGE_W-1:0]  best_age, best_l1;
    logic [PATH_W-1:0] best_path;

    // Youngest matching producer wins.
    always_comb begin
        hit       = 1'b0;
        best_age  = '0;
        best_l1   = '0;
        best_path = '0;
        for (int i = 0; i < NENT; i++) begin
            if (e_vld[i] && e_dst[i] == src && (!hit || e_age[i] < best_age)) begin
                hit       = 1'b1;
                best_age  = e_age[i];
                best_l1   = e_l1[i];
                best_path = e_path[i];
            end
        end
    end

    always_comb begin
        need_rf = 1'b0;
        use_byp = 1'b0;
        hazard  = 1'b0;
        sel     = '0;
        if (src != '0) begin
            if (!hit) begin
                need_rf = 1'b1;
            end else if (best_age >= best_l1 && best_path[best_age]) begin
                use_byp = 1'b1;
                sel     = best_age;
            end else begin
                hazard  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bypass_read_gate.sv
module bypass_read_gate
    import bypass_gate_pkg::*;
#(
    parameter int NENT  = 4,
    parameter int REG_W = 5,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [REG_W-1:0]   instr_dst,
    input  logic [1:0]         instr_cls,
    input  logic [REG_W-1:0]   src_a,
    input  logic [REG_W-1:0]   src_b,
    output logic               rd_en_a,
    output logic               rd_en_b,
    output logic [AGE_W-1:0]   sel_a,
    output logic [AGE_W-1:0]   sel_b,
    output logic               stall,
    output logic [CNT_W-1:0]   rf_reads,
    output logic [CNT_W-1:0]   byp_hits
);

    localparam int NSRC = 2;

    logic [NENT-1:0]               e_vld, e_ret, free_vec, alloc_vec;
    logic [NENT-1:0][REG_W-1:0]    e_dst;
    logic [NENT-1:0][AGE_W-1:0]    e_age, e_l1;
    logic [NENT-1:0][PATH_W-1:0]   e_path;
    logic [NSRC-1:0][REG_W-1:0]    src_vec;
    logic [NSRC-1:0]               r_rf, r_byp, r_hz;
    logic [NSRC-1:0][AGE_W-1:0]    r_sel;
    logic                          fire, alloc_req, taken;
    logic [1:0]                    rd_inc, byp_inc;
    logic [CNT_W:0]                rd_sum, byp_sum;

    assign src_vec[0] = src_a;
    assign src_vec[1] = src_b;

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        bgate_entry #(.REG_W(REG_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_vec[e]),
            .alloc_dst (instr_dst),
            .alloc_cls (instr_cls),
            .vld       (e_vld[e]),
            .retire    (e_ret[e]),
            .dst       (e_dst[e]),
            .age       (e_age[e]),
            .l1        (e_l1[e]),
            .path      (e_path[e])
        );
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        bgate_resolve #(.NENT(NENT), .REG_W(REG_W)) u_res (
            .src     (src_vec[s]),
            .e_vld   (e_vld),
            .e_dst   (e_dst),
            .e_age   (e_age),
            .e_l1    (e_l1),
            .e_path  (e_path),
            .need_rf (r_rf[s]),
            .use_byp (r_byp[s]),
            .hazard  (r_hz[s]),
            .sel     (r_sel[s])
        );
    end

    assign stall     = instr_valid && (|r_hz);
    assign fire      = instr_valid && !(|r_hz);
    assign rd_en_a   = fire && r_rf[0];
    assign rd_en_b   = fire && r_rf[1];
    assign sel_a     = fire ? r_sel[0] : '0;
    assign sel_b     = fire ? r_sel[1] : '0;
    assign alloc_req = fire && (instr_dst != '0);
    assign free_vec  = ~e_vld | e_ret;

    // Lowest free or retiring slot takes the new producer.
    always_comb begin
        alloc_vec = '0;
        taken     = 1'b0;
        for (int i = 0; i < NENT; i++) begin
            if (!taken && free_vec[i]) begin
                alloc_vec[i] = alloc_req;
                taken        = 1'b1;
            end
        end
    end

    assign rd_inc  = {1'b0, rd_en_a} + {1'b0, rd_en_b};
    assign byp_inc = {1'b0, fire && r_byp[0]} + {1'b0, fire && r_byp[1]};
    assign rd_sum  = {1'b0, rf_reads} + (CNT_W+1)'(rd_inc);
    assign byp_sum = {1'b0, byp_hits} + (CNT_W+1)'(byp_inc);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_reads <= '0;
            byp_hits <= '0;
        end else begin
            rf_reads <= rd_sum[CNT_W]  ? '1 : rd_sum[CNT_W-1:0];
            byp_hits <= byp_sum[CNT_W] ? '1 : byp_sum[CNT_W-1:0];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> (|free_vec)); // R11
    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec)); // R11
    AST_STALL_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!rd_en_a && !rd_en_b && sel_a == '0 && sel_b == '0)); // R4
    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a == '0) |-> (!rd_en_a && sel_a == '0)); // R8
    AST_RD_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_b && sel_b != '0)); // R3
    AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_reads >= $past(rf_reads)) && (byp_hits >= $past(byp_hits))); // R10

endmodule

// File: tb/bypass_read_gate_bench.sv
module bypass_read_gate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W = 5;
    localparam int CNT_W = 6;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             instr_valid = 1'b0;
    logic [REG_W-1:0] instr_dst = '0;
    logic [1:0]       instr_cls = '0;
    logic [REG_W-1:0] src_a = '0, src_b = '0;
    logic             rd_en_a, rd_en_b, stall;
    logic [2:0]       sel_a, sel_b;
    logic [CNT_W-1:0] rf_reads, byp_hits;

    int errors = 0;
    int checks = 0;

    // reference table
    bit m_on [16];
    int m_dst[16];
    int m_age[16];
    int m_cls[16];
    int m_rd  = 0;
    int m_byp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bypass_read_gate #(.NENT(4), .REG_W(REG_W), .CNT_W(CNT_W)) u_bypass_read_gate (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_dst(instr_dst),
        .instr_cls(instr_cls), .src_a(src_a), .src_b(src_b), .rd_en_a(rd_en_a),
        .rd_en_b(rd_en_b), .sel_a(sel_a), .sel_b(sel_b), .stall(stall),
        .rf_reads(rf_reads), .byp_hits(byp_hits)
    );

    function automatic int x_l1(int c);
        return (c == 2) ? 2 : (c == 3) ? 3 : 1;
    endfunction
    function automatic int x_l2(int c);
        return (c == 0) ? 2 : (c == 1) ? 3 : 4;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic resolve(int s, output int rd, output int byp, output int hz, output int sel);
        int best;
        best = -1;
        rd = 0; byp = 0; hz = 0; sel = 0;
        if (s == 0) return;
        for (int i = 0; i < 16; i++)
            if (m_on[i] && m_dst[i] == s && (best < 0 || m_age[i] < m_age[best])) best = i;
        if (best < 0) rd = 1;
        else if (m_age[best] >= x_l1(m_cls[best]) && !(m_cls[best] == 3 && m_age[best] == 4)) begin
            byp = 1; sel = m_age[best];
        end else hz = 1;
    endtask

    task automatic step(string tag, bit v, int d, int c, int a, int b);
        int rda, bya, hza, sla, rdb, byb, hzb, slb;
        bit st, fire;
        @(negedge clk);
        instr_valid = v; instr_dst = REG_W'(d); instr_cls = 2'(c);
        src_a = REG_W'(a); src_b = REG_W'(b);
        #1;
        resolve(a, rda, bya, hza, sla);
        resolve(b, rdb, byb, hzb, slb);
        st   = v && (hza != 0 || hzb != 0);
        fire = v && !st;
        chk(tag, "stall",    int'(stall),   int'(st));
        chk(tag, "rd_en_a",  int'(rd_en_a), fire ? rda : 0);
        chk(tag, "rd_en_b",  int'(rd_en_b), fire ? rdb : 0);
        chk(tag, "sel_a",    int'(sel_a),   fire ? sla : 0);
        chk(tag, "sel_b",    int'(sel_b),   fire ? slb : 0);
        chk(tag, "rf_reads", int'(rf_reads), m_rd);
        chk(tag, "byp_hits", int'(byp_hits), m_byp);
        if (fire) begin
            m_rd  = (m_rd + rda + rdb > CMAX) ? CMAX : m_rd + rda + rdb;
            m_byp = (m_byp + bya + byb > CMAX) ? CMAX : m_byp + bya + byb;
        end
        for (int i = 0; i < 16; i++)
            if (m_on[i]) begin
                if (m_age[i] >= x_l2(m_cls[i])) m_on[i] = 1'b0;
                else m_age[i]++;
            end
        if (fire && d != 0) begin
            for (int i = 0; i < 16; i++)
                if (!m_on[i]) begin
                    m_on[i] = 1'b1; m_dst[i] = d; m_age[i] = 1; m_cls[i] = c;
                    break;
                end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL R1 watchdog expired: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m_on[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset stall",    int'(stall), 0);
        chk("R1", "reset rf_reads", int'(rf_reads), 0);
        chk("R1", "reset byp_hits", int'(byp_hits), 0);
        rst_n = 1'b1;
        step("R1", 1, 0, 0, 5, 6);              // empty table: two reads
        // R3: ALU producer forwarded at ages 1 and 2
        step("R3", 1, 1, 0, 0, 0);
        step("R3", 1, 0, 0, 1, 0);
        step("R3", 1, 0, 0, 0, 1);
        step("R5", 1, 0, 0, 1, 1);              // retired: register file
        // R4: code-3 producer too young, then forwarded at age 3
        step("R4", 1, 2, 3, 0, 0);
        step("R4", 1, 0, 0, 2, 0);
        step("R4", 1, 0, 0, 2, 0);
        step("R4", 1, 0, 0, 2, 0);
        // R6: code-3 at age 4 has no path
        step("R6", 1, 3, 3, 0, 0);
        step("R6", 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0);
        step("R6", 1, 0, 0, 3, 0);
        step("R6", 1, 0, 0, 3, 0);
        // R2: code-2 latencies
        step("R2", 1, 4, 2, 0, 0);
        step("R2", 1, 0, 0, 4, 0);
        step("R2", 1, 0, 0, 4, 0);
        step("R2", 1, 0, 0, 0, 4);
        // R7: youngest producer of same register decides
        step("R7", 1, 7, 0, 0, 0);
        step("R7", 1, 7, 2, 0, 0);
        step("R7", 1, 0, 0, 7, 7);
        step("R7", 1, 6, 2, 0, 0);
        step("R7", 1, 6, 1, 0, 0);
        step("R7", 1, 0, 0, 6, 6);
        // R8: register 0
        step("R8", 1, 0, 0, 0, 0);
        step("R8", 1, 0, 3, 0, 0);
        // R9: one source stalls, other would read
        step("R9", 1, 5, 3, 0, 0);
        step("R9", 1, 0, 0, 5, 6);
        step("R9", 1, 0, 0, 6, 5);
        // R11: back-to-back writers
        for (int k = 0; k < 8; k++) step("R11", 1, (k % 4) + 1, k % 4, (k % 4) + 1, 0);
        // random mix
        for (int k = 0; k < 3000; k++)
            step("R10", ($urandom % 5) != 0, $urandom % 8, $urandom % 4, $urandom % 8, $urandom % 8);
        step("R10", 0, 0, 0, 0, 0);
        chk("R10", "rf_reads saturated", int'(rf_reads), CMAX);
        chk("R10", "byp_hits saturated", int'(byp_hits), CMAX);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule